// File: doc/BRIEF.md
# Ultra DMA Data-Out Burst Receiver

This block is the device-side receiver for an Ultra DMA transfer in which the host sends data. It stays idle until four conditions hold together: Ultra DMA operation is enabled, a DMA command that moves data is in progress, the device is requesting, and the host has acknowledged. While the burst runs, the host's source-synchronous strobe is brought into the system clock domain. Each rising or falling edge of the strobe delivers one 16-bit word to the output stream.

A CRC-16 runs over every delivered word. It is reseeded at the start of each burst. When the host withdraws its acknowledge, the burst flag drops at once. The next strobe edge then carries the host's CRC word. That word is compared with the local CRC and is never forwarded as data. A mismatch sets a sticky error flag. The flag survives any later bursts of the same command and clears only when the next command starts.

Top module: `udma_out_rx`

## Requirements
- R1: After reset, `burst_active`, `word_valid` and `crc_err` are all 0.
- R2: `burst_active` rises on the clock after `udma_en`, `dma_cmd_act`, `dev_req` and `host_ack` are all 1 together. While any one of them is 0, no burst starts.
- R3: During a burst, every strobe transition, rising or falling, yields exactly one single-cycle `word_valid` pulse. `word_data` equals the value of `hdata` at that edge. Words leave in arrival order, three clock edges after the transition.
- R4: Strobe transitions while no burst is active and no host CRC is awaited produce no `word_valid` pulse.
- R5: `burst_active` falls on the clock after `host_ack` goes to 0 during a burst.
- R6: The first strobe transition after `host_ack` falls carries the host CRC word. It produces no `word_valid` pulse and does not enter the running CRC. The receiver then returns to idle.
- R7: The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1) and is seeded with 0x4ABA at the start of every burst. It consumes all 16 bits of each word, bit 15 first: the feedback is the CRC MSB XOR the data bit, the CRC shifts left, and 0x1021 is XORed in when the feedback is 1.
- R8: A host CRC word that differs from the local CRC sets `crc_err`. The flag stays 1 through later bursts, including bursts whose CRC matches, until `cmd_start`.
- R9: `cmd_start` clears `crc_err` on the next clock. If a mismatching comparison falls in that same cycle, the clear wins and the flag reads 0.
- R10: If `host_ack` falls in the same cycle that a strobe transition is detected, that word is taken as the host CRC. It is compared, it is not output as data, and the receiver goes straight to idle without waiting for another word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run at least four times the strobe transition rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| udma_en | input | 1 | Ultra DMA operation is selected |
| dma_cmd_act | input | 1 | A DMA command that moves data is in progress |
| dev_req | input | 1 | The device is requesting a DMA transfer |
| host_ack | input | 1 | The host acknowledges the DMA transfer (active high) |
| cmd_start | input | 1 | Single-cycle pulse marking the start of a new command |
| hstrobe | input | 1 | Host data strobe, asynchronous to `clk` |
| hdata | input | 16 | Host data bus |
| word_valid | output | 1 | One-cycle pulse: `word_data` holds a received word |
| word_data | output | 16 | Received data word |
| burst_active | output | 1 | A data-out burst is in progress |
| crc_err | output | 1 | Sticky CRC mismatch flag for the current command |

## Verification
Two pairs of events can land in the same clock. The first is the host dropping acknowledge in the cycle that a synchronised strobe transition is detected. The bench provokes this by toggling the strobe, waiting two rising edges, and lowering `host_ack` before the third. It then requires that the word is not emitted, that its CRC result shows on `crc_err`, and that a later idle strobe transition changes nothing. The second pair is a mismatching CRC comparison in the same cycle as `cmd_start`. The bench times the pulse the same way and expects `crc_err` to read 0 afterwards.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_DEF = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED_DEF = 16'h4ABA;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CRC  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/udma_strobe_sync.sv
module udma_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic toggle
);
  localparam int unsigned TOP = STAGES;

  logic [TOP:0] sh_q;
  logic [TOP:0] sh_d;

  always_comb begin
    sh_d = {sh_q[TOP-1:0], strobe_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // the oldest stage against the newest synchronised stage
  assign toggle = sh_q[TOP] ^ sh_q[TOP-1];
endmodule

// File: rtl/udma_crc_unit.sv
module udma_crc_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] step;
  logic [CRC_W-1:0] crc_d;

  always_comb begin : serial_fold
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_q;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ din[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    step = c;
  end

  always_comb begin
    crc_d = crc_q;
    if (load)     crc_d = SEED;
    else if (upd) crc_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/udma_err_latch.sv
module udma_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (clr)      flag_d = 1'b0;
    else if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/udma_out_rx.sv
module udma_out_rx
  import udma_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [CRC_W-1:0] POLY   = CRC_POLY_DEF,
  parameter logic [CRC_W-1:0] SEED   = CRC_SEED_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              udma_en,
  input  logic              dma_cmd_act,
  input  logic              dev_req,
  input  logic              host_ack,
  input  logic              cmd_start,
  input  logic              hstrobe,
  input  logic [DATA_W-1:0] hdata,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              burst_active,
  output logic              crc_err
);
  rx_state_e         state_q, state_d;
  logic              tog;
  logic              burst_go;
  logic              crc_load, crc_upd, cmp_fire, crc_bad;
  logic [CRC_W-1:0]  crc_q;
  logic              wv_d;
  logic [DATA_W-1:0] wd_d;

  udma_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(hstrobe), .toggle(tog)
  );

  udma_crc_unit #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .load(crc_load), .upd(crc_upd),
    .din(hdata), .crc_q(crc_q)
  );

  udma_err_latch u_err (
    .clk(clk), .rst_n(rst_n), .clr(cmd_start), .set(crc_bad), .flag(crc_err)
  );

  assign burst_go = udma_en & dma_cmd_act & dev_req & host_ack;

  always_comb begin
    state_d  = state_q;
    wv_d     = 1'b0;
    wd_d     = word_data;
    crc_load = 1'b0;
    crc_upd  = 1'b0;
    cmp_fire = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (burst_go) begin
          state_d  = ST_DATA;
          crc_load = 1'b1;
        end
      end
      ST_DATA: begin
        if (!host_ack) begin
          // a word arriving as acknowledge drops is the host CRC
          if (tog) begin
            cmp_fire = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            state_d  = ST_CRC;
          end
        end else if (tog) begin
          wv_d    = 1'b1;
          wd_d    = hdata;
          crc_upd = 1'b1;
        end
      end
      ST_CRC: begin
        if (tog) begin
          cmp_fire = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign crc_bad = cmp_fire & (hdata != crc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      state_q    <= state_d;
      word_valid <= wv_d;
      word_data  <= wd_d;
    end
  end

  assign burst_active = (state_q == ST_DATA);
endmodule

// File: rtl/udma_out_rx_chk.sv
module udma_out_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic udma_en,
  input logic dma_cmd_act,
  input logic dev_req,
  input logic host_ack,
  input logic cmd_start,
  input logic word_valid,
  input logic burst_active,
  input logic crc_err
);
  // R2: a burst only begins when all four entry conditions held
  p_entry_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(udma_en & dma_cmd_act & dev_req & host_ack));

  // R4: words only appear inside a burst
  p_word_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> burst_active);

  // R5: acknowledge withdrawn ends the burst on the next clock
  p_exit_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !host_ack) |=> !burst_active);

  // R8: the error flag holds until a new command starts
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !cmd_start) |=> crc_err);

  // R9: command start always clears the flag
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !crc_err);
endmodule

bind udma_out_rx udma_out_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .udma_en(udma_en), .dma_cmd_act(dma_cmd_act),
  .dev_req(dev_req), .host_ack(host_ack), .cmd_start(cmd_start),
  .word_valid(word_valid), .burst_active(burst_active), .crc_err(crc_err)
);

// File: tb/tb_udma_out_rx.sv
module tb_udma_out_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        udma_en, dma_cmd_act, dev_req, host_ack, cmd_start, hstrobe;
  logic [15:0] hdata;
  logic        word_valid, burst_active, crc_err;
  logic [15:0] word_data;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] exp_w;
  logic [15:0] run_crc;

  always #10 clk = ~clk;

  udma_out_rx dut (
    .clk(clk), .rst_n(rst_n), .udma_en(udma_en), .dma_cmd_act(dma_cmd_act),
    .dev_req(dev_req), .host_ack(host_ack), .cmd_start(cmd_start),
    .hstrobe(hstrobe), .hdata(hdata), .word_valid(word_valid),
    .word_data(word_data), .burst_active(burst_active), .crc_err(crc_err)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      logic fb = r[15] ^ w[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: each emitted word must match the head of the scoreboard (R3, R4)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && word_valid === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R6: unexpected word actual %h expected none", word_data);
      end else begin
        exp_w = exp_q.pop_front();
        if (word_data !== exp_w) begin
          errors++;
          $display("FAIL R3: word actual %h expected %h", word_data, exp_w);
        end
      end
    end
  end

  task automatic send_word(input logic [15:0] w, input bit in_burst);
    @(negedge clk);
    hdata   = w;
    hstrobe = ~hstrobe;
    if (in_burst) begin
      exp_q.push_back(w);
      run_crc = ref_crc(run_crc, w);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic open_burst();
    @(negedge clk);
    udma_en = 1'b1; dma_cmd_act = 1'b1; dev_req = 1'b1; host_ack = 1'b1;
    run_crc = 16'h4ABA;
    @(negedge clk);
    chk("R2 burst entry", 16'(burst_active), 16'h1);
  endtask

  task automatic close_burst(input logic [15:0] crcw, input logic exp_err, input string tag);
    @(negedge clk);
    host_ack = 1'b0;
    @(negedge clk);
    chk("R5 burst exit", 16'(burst_active), 16'h0);
    send_word(crcw, 1'b0);
    chk(tag, 16'(crc_err), 16'(exp_err));
    dev_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; udma_en = 1'b0; dma_cmd_act = 1'b0; dev_req = 1'b0;
    host_ack = 1'b0; cmd_start = 1'b0; hstrobe = 1'b0; hdata = 16'h0;
    run_crc = 16'h4ABA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 burst_active", 16'(burst_active), 16'h0);
    chk("R1 word_valid", 16'(word_valid), 16'h0);
    chk("R1 crc_err", 16'(crc_err), 16'h0);

    // R2/R4: each single missing condition blocks entry; strobe is ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      udma_en = (k != 0); dma_cmd_act = (k != 1); dev_req = (k != 2); host_ack = (k != 3);
      repeat (2) @(negedge clk);
      chk("R2 missing condition", 16'(burst_active), 16'h0);
      send_word(16'hDEAD ^ 16'(k), 1'b0);
    end
    @(negedge clk);
    udma_en = 1'b0; dma_cmd_act = 1'b0; dev_req = 1'b0; host_ack = 1'b0;

    // R3/R7: a good burst with both strobe polarities
    open_burst();
    send_word(16'h1234, 1'b1);
    send_word(16'hFFFF, 1'b1);
    send_word(16'h0000, 1'b1);
    send_word(16'hA5C3, 1'b1);
    send_word(16'h8001, 1'b1);
    close_burst(run_crc, 1'b0, "R7 matching CRC");
    chk("R3 all words seen", 16'(exp_q.size()), 16'h0);

    // R6/R8: a bad CRC sets the flag
    open_burst();
    send_word(16'h0F0F, 1'b1);
    send_word(16'h7E81, 1'b1);
    close_burst(run_crc ^ 16'h0001, 1'b1, "R8 mismatch sets flag");

    // R7/R8: a matching burst later in the command keeps the flag (seed reloaded)
    open_burst();
    send_word(16'h3C3C, 1'b1);
    close_burst(run_crc, 1'b1, "R8 flag stays set");

    // R9: command start clears
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    chk("R9 clear", 16'(crc_err), 16'h0);

    // R9: clear coincides with a mismatching comparison
    open_burst();
    send_word(16'h5555, 1'b1);
    @(negedge clk); host_ack = 1'b0;
    @(negedge clk);
    hdata = ~run_crc; hstrobe = ~hstrobe;
    @(posedge clk); @(posedge clk);
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    chk("R9 clear wins over mismatch", 16'(crc_err), 16'h0);
    repeat (2) @(negedge clk);
    dev_req = 1'b0;

    // R10: acknowledge drops in the cycle a transition is detected
    open_burst();
    send_word(16'hC001, 1'b1);
    send_word(16'h00FF, 1'b1);
    @(negedge clk);
    hdata = run_crc; hstrobe = ~hstrobe;
    @(posedge clk); @(posedge clk);
    @(negedge clk); host_ack = 1'b0;
    @(negedge clk);
    chk("R10 burst ended", 16'(burst_active), 16'h0);
    repeat (2) @(negedge clk);
    chk("R10 coincident CRC matched", 16'(crc_err), 16'h0);
    send_word(16'hBEEF, 1'b0);
    chk("R10 no further CRC awaited", 16'(crc_err), 16'h0);
    chk("R6 no CRC word emitted", 16'(exp_q.size()), 16'h0);
    dev_req = 1'b0;

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule